// File: doc/BRIEF.md
# Way-Tag L2 Access Controller

This controller sits between an L1 data cache and a set-associative L2 cache that runs write-through. When a line is filled into L1, L2 also returns the number of the way that holds it. The controller keeps that way number, with a valid flag, in a small table that has one entry per L1 line. A later write that hits in L1 is forwarded to L2 with only that way enabled, so L2 behaves like a direct-mapped array for the most common L2 traffic.

Every other kind of access enables all ways. That covers write misses, writes whose table entry is invalid and read misses. Read hits leave L2 untouched. Write-through traffic passes through a small FIFO. The FIFO holds each accepted write together with the way tag looked up for it, so the processor can move on while L2 drains the queue. When the FIFO is full, new writes are held off with a stall signal.

Top module: `waytag_l2_ctrl`

## Requirements
- R1: After reset every table entry is invalid, the write buffer is empty (`wb_empty`=1, `wb_full`=0, `l2_wr_valid`=0) and both enable vectors are zero.
- R2: A cycle with `fill_valid`=1 marks entry `fill_idx` valid and stores `fill_way` in it. If an invalidation names the same index in the same cycle, the fill prevails.
- R3: A write hit (`req_valid`=1, `req_write`=1, `req_hit`=1) on a valid entry queues a write whose `l2_wr_en` at the head of the buffer has only bit `way` set.
- R4: A write miss (`req_hit`=0) queues a write whose `l2_wr_en` has every bit set.
- R5: A write hit on an invalid entry queues a write whose `l2_wr_en` has every bit set.
- R6: A read hit, or a cycle with no request, gives `l2_rd_en`=0 in the following cycle.
- R7: A read miss gives `l2_rd_en` with every bit set in the cycle after the request, for that one cycle only.
- R8: A cycle with `inv_valid`=1 and no fill to the same index makes entry `inv_idx` invalid.
- R9: Queued writes leave in the order they were accepted. The head is shown on `l2_wr_idx`/`l2_wr_data` while `l2_wr_valid`=1, and it is removed on a cycle with `l2_wr_ready`=1. `l2_wr_en` is zero while the buffer is empty.
- R10: The buffer holds 4 entries (`WB_DEPTH`). When it is full, `wb_full`=1, a write request raises `req_stall` in the same cycle, and that write is not queued.
- R11: A write looks up the table as it stood before any fill or invalidation in the same cycle.
- R12: Read requests are never stalled and still drive `l2_rd_en` while the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | L1 access present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_hit | input | 1 | L1 lookup result |
| req_idx | input | IDX_W | L1 line index of the access |
| req_data | input | DATA_W | Store data for write-through |
| fill_valid | input | 1 | L1 line filled from L2 this cycle |
| fill_idx | input | IDX_W | L1 line being filled |
| fill_way | input | WAY_W | L2 way that supplied the line |
| inv_valid | input | 1 | L1 line invalidated or evicted |
| inv_idx | input | IDX_W | Line being invalidated |
| l2_wr_ready | input | 1 | L2 accepts the head write |
| req_stall | output | 1 | Write request held off, buffer full |
| l2_rd_en | output | NUM_WAYS | Way enables for read-miss lookup |
| l2_wr_valid | output | 1 | Write pending toward L2 |
| l2_wr_en | output | NUM_WAYS | Way enables for the head write |
| l2_wr_idx | output | IDX_W | Line index of the head write |
| l2_wr_data | output | DATA_W | Data of the head write |
| wb_full | output | 1 | Write buffer full |
| wb_empty | output | 1 | Write buffer empty |

## Verification
The bench builds the block with 4 ways, 8 L1 lines, a 4-entry buffer and 16-bit data. With those values the buffer reaches full after a few stalled cycles of `l2_wr_ready`, and a short random phase revisits every line many times. That lets fills, invalidations and writes collide on the same index. With 4 ways, a one-hot enable can be told apart from an all-ways enable for every stored way number, including way 0 and the highest way.

// File: rtl/waytag_pkg.sv
package waytag_pkg;

   typedef enum logic [1:0] {
      AK_IDLE      = 2'd0,
      AK_READ_HIT  = 2'd1,
      AK_READ_MISS = 2'd2,
      AK_WRITE     = 2'd3
   } access_kind_e;

   function automatic access_kind_e classify(input logic valid,
                                             input logic write,
                                             input logic hit);
      if (!valid)     return AK_IDLE;
      else if (write) return AK_WRITE;
      else if (hit)   return AK_READ_HIT;
      else            return AK_READ_MISS;
   endfunction

endpackage

// File: rtl/waytag_array.sv
module waytag_array #(
   parameter int LINES = 8,
   parameter int WAY_W = 2,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_valid,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [WAY_W-1:0] fill_way,
   input  logic             inv_valid,
   input  logic [IDX_W-1:0] inv_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [WAY_W-1:0] rd_way
);

   logic [LINES-1:0] vld_q;
   logic [WAY_W-1:0] way_q [LINES];

   always_ff @(posedge clk) begin
      for (int i = 0; i < LINES; i++) begin
         if (!rst_n) begin
            vld_q[i] <= 1'b0;
            way_q[i] <= '0;
         end else if (fill_valid && fill_idx == IDX_W'(i)) begin
            vld_q[i] <= 1'b1;
            way_q[i] <= fill_way;
         end else if (inv_valid && inv_idx == IDX_W'(i)) begin
            vld_q[i] <= 1'b0;
         end
      end
   end

   assign rd_valid = vld_q[rd_idx];
   assign rd_way   = way_q[rd_idx];

   // R2: a fill leaves its entry valid with the returned way
   a_r2_fill_records: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> vld_q[$past(fill_idx)] && way_q[$past(fill_idx)] == $past(fill_way));

   // R8: an invalidation without a competing fill clears the entry
   a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !(fill_valid && fill_idx == inv_idx)) |=> !vld_q[$past(inv_idx)]);

endmodule

// File: rtl/waytag_decoder.sv
module waytag_decoder #(
   parameter int NUM_WAYS = 4,
   localparam int WAY_W = $clog2(NUM_WAYS)
) (
   input  logic                enable,
   input  logic                known,
   input  logic [WAY_W-1:0]    way,
   output logic [NUM_WAYS-1:0] way_en
);

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      assign way_en[w] = enable & (~known | (way == WAY_W'(w)));
   end

endmodule

// File: rtl/waytag_wbuf.sv
module waytag_wbuf #(
   parameter int DEPTH = 4,
   parameter int W     = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   assign full  = (cnt == CNT_W'(DEPTH));
   assign empty = (cnt == '0);
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   cnt <= cnt + CNT_W'(1);
            2'b01:   cnt <= cnt - CNT_W'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   // R10: nothing is written into a full buffer
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);

   // R9: nothing is taken from an empty buffer
   a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);

   // R9: occupancy is unchanged when no entry moves
   a_r9_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> $stable(cnt));

endmodule

// File: rtl/waytag_l2_ctrl.sv
module waytag_l2_ctrl
   import waytag_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   parameter int L1_LINES = 8,
   parameter int WB_DEPTH = 4,
   parameter int DATA_W   = 16,
   localparam int WAY_W = $clog2(NUM_WAYS),
   localparam int IDX_W = $clog2(L1_LINES),
   localparam int ENT_W = 1 + WAY_W + IDX_W + DATA_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic                req_hit,
   input  logic [IDX_W-1:0]    req_idx,
   input  logic [DATA_W-1:0]   req_data,
   input  logic                fill_valid,
   input  logic [IDX_W-1:0]    fill_idx,
   input  logic [WAY_W-1:0]    fill_way,
   input  logic                inv_valid,
   input  logic [IDX_W-1:0]    inv_idx,
   input  logic                l2_wr_ready,
   output logic                req_stall,
   output logic [NUM_WAYS-1:0] l2_rd_en,
   output logic                l2_wr_valid,
   output logic [NUM_WAYS-1:0] l2_wr_en,
   output logic [IDX_W-1:0]    l2_wr_idx,
   output logic [DATA_W-1:0]   l2_wr_data,
   output logic                wb_full,
   output logic                wb_empty
);

   initial begin
      assert (NUM_WAYS >= 2) else $error("NUM_WAYS must be at least 2");
      assert (L1_LINES >= 2 && (L1_LINES & (L1_LINES - 1)) == 0)
         else $error("L1_LINES must be a power of two, at least 2");
      assert (WB_DEPTH >= 2) else $error("WB_DEPTH must be at least 2");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   access_kind_e     kind;
   logic             tag_vld;
   logic [WAY_W-1:0] tag_way;
   logic             wr_req, push, pop, known;
   logic [ENT_W-1:0] push_ent, head_ent;
   logic             head_known;
   logic [WAY_W-1:0] head_way;
   logic [NUM_WAYS-1:0] rd_en_q;

   assign kind   = classify(req_valid, req_write, req_hit);
   assign wr_req = (kind == AK_WRITE);

   waytag_array #(.LINES(L1_LINES), .WAY_W(WAY_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_valid(fill_valid),
      .fill_idx  (fill_idx),
      .fill_way  (fill_way),
      .inv_valid (inv_valid),
      .inv_idx   (inv_idx),
      .rd_idx    (req_idx),
      .rd_valid  (tag_vld),
      .rd_way    (tag_way)
   );

   assign known     = req_hit & tag_vld;
   assign push      = wr_req & ~wb_full;
   assign req_stall = wr_req & wb_full;
   assign push_ent  = {known, tag_way, req_idx, req_data};
   assign pop       = ~wb_empty & l2_wr_ready;

   waytag_wbuf #(.DEPTH(WB_DEPTH), .W(ENT_W)) u_wbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_data(push_ent),
      .pop      (pop),
      .head     (head_ent),
      .full     (wb_full),
      .empty    (wb_empty)
   );

   assign {head_known, head_way, l2_wr_idx, l2_wr_data} = head_ent;
   assign l2_wr_valid = ~wb_empty;

   waytag_decoder #(.NUM_WAYS(NUM_WAYS)) u_dec (
      .enable(l2_wr_valid),
      .known (head_known),
      .way   (head_way),
      .way_en(l2_wr_en)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rd_en_q <= '0;
      else        rd_en_q <= (kind == AK_READ_MISS) ? '1 : '0;
   end
   assign l2_rd_en = rd_en_q;

   // R7: a read miss opens every way on the next cycle
   a_r7_miss_all_ways: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !req_hit) |=> (&l2_rd_en));

   // R6: no read enables after anything but a read miss
   a_r6_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write && !req_hit) |=> (l2_rd_en == '0));

   // R3: a head write enables exactly one way or all of them
   a_r3_wr_en_shape: assert property (@(posedge clk) disable iff (!rst_n)
      l2_wr_valid |-> ($countones(l2_wr_en) == 1 || (&l2_wr_en)));

   // R9: no write enables while nothing is pending
   a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !l2_wr_valid |-> (l2_wr_en == '0));

   // R9: a stalled head is held unchanged
   a_r9_head_held: assert property (@(posedge clk) disable iff (!rst_n)
      (l2_wr_valid && !l2_wr_ready) |=>
         (l2_wr_valid && $stable(l2_wr_idx) && $stable(l2_wr_data) && $stable(l2_wr_en)));

   // R12: read requests never see a stall
   a_r12_reads_free: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |-> !req_stall);

endmodule

// File: tb/sim_waytag_l2_ctrl.sv
module sim_waytag_l2_ctrl;

   localparam int NW = 4, LN = 8, DP = 4, DW = 16;
   localparam int WW = 2, IW = 3;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0, req_hit = 0;
   logic [IW-1:0] req_idx = 0, fill_idx = 0, inv_idx = 0;
   logic [DW-1:0] req_data = 0;
   logic fill_valid = 0, inv_valid = 0, l2_wr_ready = 1;
   logic [WW-1:0] fill_way = 0;
   logic req_stall, l2_wr_valid, wb_full, wb_empty;
   logic [NW-1:0] l2_rd_en, l2_wr_en;
   logic [IW-1:0] l2_wr_idx;
   logic [DW-1:0] l2_wr_data;

   waytag_l2_ctrl #(.NUM_WAYS(NW), .L1_LINES(LN), .WB_DEPTH(DP), .DATA_W(DW)) u0 (.*);

   always #4 clk = ~clk;

   int checks = 0, fails = 0;
   int m_vld [LN];
   int m_way [LN];
   int q_en[$], q_idx[$], q_data[$];
   int rd_exp = 0;
   string tag_en = "R3";

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_outputs();
      check("R7", "l2_rd_en", int'(l2_rd_en), rd_exp);
      check("R9", "l2_wr_valid", int'(l2_wr_valid), int'(q_en.size() > 0));
      check("R10", "wb_full", int'(wb_full), int'(q_en.size() == DP));
      check("R1", "wb_empty", int'(wb_empty), int'(q_en.size() == 0));
      if (q_en.size() > 0) begin
         check(tag_en, "l2_wr_en", int'(l2_wr_en), q_en[0]);
         check("R9", "l2_wr_idx", int'(l2_wr_idx), q_idx[0]);
         check("R9", "l2_wr_data", int'(l2_wr_data), q_data[0]);
      end else begin
         check("R9", "l2_wr_en empty", int'(l2_wr_en), 0);
      end
   endtask

   // one clock: inputs already driven at a falling edge
   task automatic step();
      bit wr, full;
      int en;
      #1;
      wr   = req_valid && req_write;
      full = (q_en.size() == DP);
      check("R10", "req_stall", int'(req_stall), int'(wr && full));
      if (req_valid && !req_write) check("R12", "read stall", int'(req_stall), 0);
      // R11: look up before this cycle's table updates
      en = (req_hit && m_vld[req_idx] != 0) ? (1 << m_way[req_idx]) : 4'hF;
      rd_exp = (req_valid && !req_write && !req_hit) ? 4'hF : 0;
      if (q_en.size() > 0 && l2_wr_ready) begin
         void'(q_en.pop_front()); void'(q_idx.pop_front()); void'(q_data.pop_front());
      end
      if (wr && !full) begin
         q_en.push_back(en); q_idx.push_back(int'(req_idx)); q_data.push_back(int'(req_data));
      end
      if (inv_valid) m_vld[inv_idx] = 0;
      if (fill_valid) begin m_vld[fill_idx] = 1; m_way[fill_idx] = int'(fill_way); end
      @(posedge clk);
      @(negedge clk);
      compare_outputs();
   endtask

   task automatic idle();
      req_valid = 0; fill_valid = 0; inv_valid = 0;
   endtask

   task automatic wr(logic hit, int idx, int data);
      idle(); req_valid = 1; req_write = 1; req_hit = hit;
      req_idx = IW'(idx); req_data = DW'(data); step();
   endtask

   task automatic rd(logic hit, int idx);
      idle(); req_valid = 1; req_write = 0; req_hit = hit; req_idx = IW'(idx); step();
   endtask

   task automatic fill(int idx, int way);
      idle(); fill_valid = 1; fill_idx = IW'(idx); fill_way = WW'(way); step();
   endtask

   task automatic inval(int idx);
      idle(); inv_valid = 1; inv_idx = IW'(idx); step();
   endtask

   task automatic drain();
      idle(); l2_wr_ready = 1;
      while (q_en.size() > 0) step();
      step();
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < LN; i++) begin m_vld[i] = 0; m_way[i] = 0; end
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      check("R1", "reset rd_en", int'(l2_rd_en), 0);
      check("R1", "reset wr_en", int'(l2_wr_en), 0);
      check("R1", "reset empty", int'(wb_empty), 1);
      check("R1", "reset full", int'(wb_full), 0);

      tag_en = "R5"; wr(1, 3, 16'h1111); drain();          // hit, entry invalid
      tag_en = "R2"; fill(3, 2); wr(1, 3, 16'h2222); drain();
      tag_en = "R3"; fill(5, 0); wr(1, 5, 16'h3333);
      fill(6, 3); wr(1, 6, 16'h4444); drain();
      tag_en = "R4"; wr(0, 3, 16'h5555); drain();          // miss on filled line
      rd(1, 3); rd(0, 3); rd(0, 4); idle(); step();         // R6, R7
      tag_en = "R8"; inval(3); wr(1, 3, 16'h6666); drain();
      // R2: fill and invalidate same line, fill prevails
      tag_en = "R2"; idle(); fill_valid = 1; fill_idx = 1; fill_way = 1;
      inv_valid = 1; inv_idx = 1; step(); wr(1, 1, 16'h7777); drain();
      // R11: write and fill to same line in one cycle uses old entry
      tag_en = "R11"; idle(); req_valid = 1; req_write = 1; req_hit = 1; req_idx = 2;
      req_data = 16'h8888; fill_valid = 1; fill_idx = 2; fill_way = 1; step();
      wr(1, 2, 16'h9999); drain();
      // R10 / R12: fill the buffer with L2 stalled
      tag_en = "R10"; l2_wr_ready = 0;
      for (int k = 0; k < 6; k++) begin
         idle(); req_valid = 1; req_write = 1; req_hit = 1;
         req_idx = IW'(k); req_data = DW'(16'hA000 + k); step();
      end
      rd(0, 0); rd(1, 0);
      drain();
      // random mix
      tag_en = "R9";
      for (int c = 0; c < 400; c++) begin
         req_valid = ($urandom % 4) != 0; req_write = $urandom % 2; req_hit = $urandom % 2;
         req_idx = IW'($urandom); req_data = DW'($urandom);
         fill_valid = ($urandom % 3) == 0; fill_idx = IW'($urandom); fill_way = WW'($urandom);
         inv_valid = ($urandom % 8) == 0; inv_idx = IW'($urandom);
         l2_wr_ready = ($urandom % 5) < 3;
         step();
      end
      drain();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule